// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a supervisory timer for a processor subsystem. Software writes a timeout constant, sets the enable bit, and then must keep the timer alive. It does that by writing a two-byte key pair to a feed register, which reloads a 32-bit down-counter. The counter steps once every four clock cycles. If the counter runs out, or software writes a malformed key pair, the block raises one event. Depending on a mode bit, that event is either a one-cycle system reset request or a one-cycle interrupt pulse.

Software cannot switch the watchdog off once it is enabled. The enable and mode bits are set-only, and only a fire event or a warm reset clears enable. A timeout flag survives the warm reset, which the chip's reset generator applies when the watchdog fires, so code that boots afterwards can see why it restarted. Only the cold reset or an explicit software clear removes that flag. While a debugger asserts the halt input, the countdown is frozen.

The register port is a single-cycle access port. There are four word registers, selected by a 2-bit address. Reads return data combinationally in the cycle of the access.

Top module: `wdt_guard`

## Requirements
- R1: Register map: address 0 is control (bit0 enable, bit1 reset-mode, bit2 timeout flag, bit3 running, other bits read 0); address 1 is the timeout constant; address 2 is the feed register, which reads 0; address 3 is the current count. After a cold reset, control reads 0, the count reads 0, and both event outputs are low.
- R2: A control write sets enable and mode wherever the written bit is 1, and writing 0 never clears them. Enable and mode are cleared only by a reset.
- R3: With enable clear, a valid feed has no effect. After enable is set, the count stays idle and running stays 0 until the first valid feed.
- R4: A valid feed is a write of 0xAA to address 2 (low byte compared) followed, at the next access, by a write of 0x55 to address 2; idle cycles between the two are allowed. A valid feed loads the count with the timeout constant, raised to 256 when the constant is below 256, and sets running.
- R5: When a valid feed loads N at clock edge E, the count expires at edge E+4N.
- R6: A fire event produces a single-cycle pulse on the reset-request output when mode is 1, or on the interrupt output when mode is 0. The two outputs are never high together.
- R7: With enable set, a malformed feed fires at the edge of the offending access. Malformed means any access other than a 0x55 feed write following 0xAA, or a feed write of any value other than 0xAA when no 0xAA is pending.
- R8: Expiry sets the timeout flag. A malformed feed does not set it. A control write with bit2 = 0 clears it, the warm reset leaves it, and the cold reset clears it.
- R9: While the debug halt input is high, the count and the sub-count do not advance.
- R10: A fire event clears enable and running. Mode stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Cold reset, active low, asynchronous; clears everything, including the timeout flag |
| rst_n | input | 1 | Warm reset, active low, asynchronous; clears everything except the timeout flag |
| dbg_halt_i | input | 1 | Debug halt; freezes the countdown |
| acc_en_i | input | 1 | Register access in this cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 2 | Register select |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for the addressed register |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest cases to reach are the exact expiry edge and the frozen count under debug halt. The expiry edge lies more than a thousand cycles after the feed, and the halt must hold the count at a sub-count position where the block makes no visible change. The stimulus uses the 256-count floor, so a timeout constant of 0 gives a 1024-cycle window. The bench counts clock edges from the edge of the 0x55 write and samples one cycle before and exactly at the predicted expiry. For the halt case, it raises halt in the same cycle the feed completes and holds it far longer than the timeout. It then reads the count back and repeats the exact-edge check from the moment of release.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TC   = 2'd1,
        REG_FEED = 2'd2,
        REG_TV   = 2'd3
    } wdt_reg_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_FLAG = 2;
    localparam int CTRL_RUN  = 3;

endpackage

// File: rtl/wdt_guard_feed.sv
module wdt_guard_feed #(
    parameter logic [7:0] KEY_ARM  = 8'hAA,
    parameter logic [7:0] KEY_FIRE = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en_i,
    input  logic       acc_we_i,
    input  logic       is_feed_i,
    input  logic [7:0] data_i,
    output logic       feed_ok_o,
    output logic       feed_bad_o
);

    logic armed_q, armed_d;

    always_comb begin
        armed_d    = armed_q;
        feed_ok_o  = 1'b0;
        feed_bad_o = 1'b0;
        if (acc_en_i) begin
            if (armed_q) begin
                armed_d = 1'b0;
                if (acc_we_i && is_feed_i && data_i == KEY_FIRE) begin
                    feed_ok_o = 1'b1;
                end else begin
                    feed_bad_o = 1'b1;
                end
            end else if (acc_we_i && is_feed_i) begin
                if (data_i == KEY_ARM) begin
                    armed_d = 1'b1;
                end else begin
                    feed_bad_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

endmodule

// File: rtl/wdt_guard_presc.sv
module wdt_guard_presc #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);

    logic [PRE_W-1:0] pre_q, pre_d;

    always_comb begin
        tick_o = run_i && (&pre_q);
        if (clr_i) begin
            pre_d = '0;
        end else if (run_i) begin
            pre_d = pre_q + 1'b1;
        end else begin
            pre_d = pre_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int         CNT_W    = 32,
    parameter int         PRE_W    = 2,
    parameter int         MIN_TC   = 256,
    parameter int         TC_RST   = 255,
    parameter logic [7:0] KEY_ARM  = 8'hAA,
    parameter logic [7:0] KEY_FIRE = 8'h55
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             dbg_halt_i,
    input  logic             acc_en_i,
    input  logic             acc_we_i,
    input  logic [1:0]       acc_addr_i,
    input  logic [CNT_W-1:0] acc_wdata_i,
    output logic [CNT_W-1:0] acc_rdata_o,
    output logic             rst_req_o,
    output logic             irq_o
);
    import wdt_guard_pkg::*;

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_TC);
    localparam logic [CNT_W-1:0] TC_RV = CNT_W'(TC_RST);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             mode;
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tc;
        logic             rst_req;
        logic             irq;
    } wdt_state_t;

    wdt_state_t s_q, s_d;
    logic       flag_q, flag_d;

    wdt_reg_e         acc_reg;
    logic             ctrl_wr, tc_wr;
    logic             feed_ok, feed_bad, tick;
    logic             load, expire, fire;
    logic [CNT_W-1:0] tc_eff;
    logic             en_q, run_q;
    logic [CNT_W-1:0] cnt_q;

    assign acc_reg = wdt_reg_e'(acc_addr_i);
    assign ctrl_wr = acc_en_i && acc_we_i && acc_reg == REG_CTRL;
    assign tc_wr   = acc_en_i && acc_we_i && acc_reg == REG_TC;
    assign en_q    = s_q.en;
    assign run_q   = s_q.run;
    assign cnt_q   = s_q.cnt;

    wdt_guard_feed #(
        .KEY_ARM  (KEY_ARM),
        .KEY_FIRE (KEY_FIRE)
    ) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en_i   (acc_en_i),
        .acc_we_i   (acc_we_i),
        .is_feed_i  (acc_reg == REG_FEED),
        .data_i     (acc_wdata_i[7:0]),
        .feed_ok_o  (feed_ok),
        .feed_bad_o (feed_bad)
    );

    wdt_guard_presc #(
        .PRE_W (PRE_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.run && !dbg_halt_i),
        .clr_i  (load),
        .tick_o (tick)
    );

    always_comb begin
        tc_eff = (s_q.tc < MIN_V) ? MIN_V : s_q.tc;
        load   = feed_ok && s_q.en;
        expire = tick && s_q.run && (s_q.cnt == ONE_V) && !load;
        fire   = expire || (feed_bad && s_q.en);

        s_d         = s_q;
        s_d.rst_req = 1'b0;
        s_d.irq     = 1'b0;
        flag_d      = flag_q;

        if (ctrl_wr) begin
            s_d.en   = s_q.en   | acc_wdata_i[CTRL_EN];
            s_d.mode = s_q.mode | acc_wdata_i[CTRL_MODE];
            flag_d   = flag_q   & acc_wdata_i[CTRL_FLAG];
        end
        if (tc_wr) begin
            s_d.tc = acc_wdata_i;
        end
        if (load) begin
            s_d.cnt = tc_eff;
            s_d.run = 1'b1;
        end else if (tick && s_q.run) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (fire) begin
            s_d.en      = 1'b0;
            s_d.run     = 1'b0;
            s_d.rst_req = s_q.mode;
            s_d.irq     = !s_q.mode;
        end
        if (expire) begin
            flag_d = 1'b1;
        end
    end

    always_comb begin
        acc_rdata_o = '0;
        case (acc_reg)
            REG_CTRL: begin
                acc_rdata_o[CTRL_EN]   = s_q.en;
                acc_rdata_o[CTRL_MODE] = s_q.mode;
                acc_rdata_o[CTRL_FLAG] = flag_q;
                acc_rdata_o[CTRL_RUN]  = s_q.run;
            end
            REG_TC:   acc_rdata_o = s_q.tc;
            REG_TV:   acc_rdata_o = s_q.cnt;
            default:  acc_rdata_o = '0;
        endcase
    end

    assign rst_req_o = s_q.rst_req;
    assign irq_o     = s_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en      <= 1'b0;
            s_q.mode    <= 1'b0;
            s_q.run     <= 1'b0;
            s_q.cnt     <= '0;
            s_q.tc      <= TC_RV;
            s_q.rst_req <= 1'b0;
            s_q.irq     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int CNT_W  = 32,
    parameter int MIN_TC = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_halt_i,
    input logic             rst_req_o,
    input logic             irq_o,
    input logic             en_q,
    input logic             run_q,
    input logic             flag_q,
    input logic             load,
    input logic [CNT_W-1:0] cnt_q
);

    assert_single_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_o));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) |=> !(rst_req_o || irq_o));

    assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> (rst_req_o || irq_o));

    assert_run_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> en_q);

    assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));

    assert_load_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run_q && cnt_q >= CNT_W'(MIN_TC)));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt_i && !load) |=> $stable(cnt_q));

    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (rst_req_o || irq_o));

endmodule

bind wdt_guard wdt_guard_chk #(
    .CNT_W  (CNT_W),
    .MIN_TC (MIN_TC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_halt_i (dbg_halt_i),
    .rst_req_o  (rst_req_o),
    .irq_o      (irq_o),
    .en_q       (en_q),
    .run_q      (run_q),
    .flag_q     (flag_q),
    .load       (load),
    .cnt_q      (cnt_q)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        acc_en_i = 1'b0;
    logic        acc_we_i = 1'b0;
    logic [1:0]  acc_addr_i = 2'd0;
    logic [31:0] acc_wdata_i = '0;
    logic [31:0] acc_rdata_o;
    logic        rst_req_o, irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wdt_guard u_dut (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .dbg_halt_i  (dbg_halt_i),
        .acc_en_i    (acc_en_i),
        .acc_we_i    (acc_we_i),
        .acc_addr_i  (acc_addr_i),
        .acc_wdata_i (acc_wdata_i),
        .acc_rdata_o (acc_rdata_o),
        .rst_req_o   (rst_req_o),
        .irq_o       (irq_o)
    );

    // timeout constant written, expected count right after the feed (R4 floor)
    localparam logic [63:0] VEC [7] = '{
        {32'h0000_0000, 32'h0000_0100},
        {32'h0000_0001, 32'h0000_0100},
        {32'h0000_00FF, 32'h0000_0100},
        {32'h0000_0100, 32'h0000_0100},
        {32'h0000_0101, 32'h0000_0101},
        {32'h0000_1000, 32'h0000_1000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // all access tasks are entered at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        acc_en_i = 1'b1; acc_we_i = 1'b1; acc_addr_i = a; acc_wdata_i = d;
        @(negedge clk);
        acc_en_i = 1'b0; acc_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        acc_en_i = 1'b1; acc_we_i = 1'b0; acc_addr_i = a;
        #1 d = acc_rdata_o;
        @(negedge clk);
        acc_en_i = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_fire(input string req, input int n, input logic rst_mode);
        idle(4 * n - 1);
        chk({req, " quiet before expiry"}, {30'd0, rst_req_o, irq_o}, 32'd0);
        idle(1);
        chk({req, " fire at 4N"}, {30'd0, rst_req_o, irq_o}, {30'd0, rst_mode, !rst_mode});
        idle(1);
        chk({req, " single pulse"}, {30'd0, rst_req_o, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd3, v); chk("R1 count", v, 32'h0);
        rd(2'd2, v); chk("R1 feed reads 0", v, 32'h0);
        chk("R1 outputs", {30'd0, rst_req_o, irq_o}, 32'd0);

        // R3 feed while disabled ignored; no start before first feed
        feed();
        rd(2'd0, v); chk("R3 disabled feed ctrl", v, 32'h0);
        rd(2'd3, v); chk("R3 disabled feed count", v, 32'h0);
        wr(2'd0, 32'h1);
        idle(20);
        rd(2'd0, v); chk("R3 enabled not running", v, 32'h1);
        rd(2'd3, v); chk("R3 count idle", v, 32'h0);

        // R4 reload with floor, table driven
        foreach (VEC[i]) begin
            wr(2'd1, VEC[i][63:32]);
            feed();
            rd(2'd3, v); chk("R4 reload value", v, VEC[i][31:0]);
        end
        rd(2'd1, v); chk("R1 constant readback", v, 32'hFFFF_FFFF);

        // R2 enable cannot be cleared
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 enable sticky", v, 32'h9);

        // R5 exact expiry, R6 interrupt mode, R8 flag, R10 clear
        wr(2'd1, 32'h0);
        feed();
        expect_fire("R5 R6 irq mode", 256, 1'b0);
        rd(2'd0, v); chk("R8 R10 after expiry", v, 32'h4);

        // R9 debug halt freezes countdown
        wr(2'd0, 32'h1);
        feed();
        dbg_halt_i = 1'b1;
        idle(2000);
        rd(2'd3, v); chk("R9 count frozen", v, 32'h100);
        chk("R9 no fire during halt", {30'd0, rst_req_o, irq_o}, 32'd0);
        dbg_halt_i = 1'b0;
        expect_fire("R9 resume", 256, 1'b0);

        // R8 software clear; R7 other access between keys, R6 reset mode
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R8 flag cleared", v, 32'h0);
        wr(2'd0, 32'h3);
        rd(2'd0, v); chk("R2 mode set", v, 32'h3);
        wr(2'd2, 32'hAA);
        rd(2'd1, v);
        chk("R7 access between keys", {30'd0, rst_req_o, irq_o}, 32'h2);
        rd(2'd0, v); chk("R8 R10 bad feed no flag", v, 32'h2);

        // R7 wrong second key
        wr(2'd0, 32'h1);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h12);
        chk("R7 wrong second key", {30'd0, rst_req_o, irq_o}, 32'h2);

        // R7 feed write without a pending first key
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h33);
        chk("R7 stray feed write", {30'd0, rst_req_o, irq_o}, 32'h2);

        // R4 idle cycles between keys still valid
        wr(2'd0, 32'h1);
        wr(2'd2, 32'hAA);
        idle(3);
        wr(2'd2, 32'h55);
        rd(2'd0, v); chk("R4 idle between keys", v, 32'hB);

        // R5 R6 expiry in reset mode, R8 flag through warm reset
        feed();
        expect_fire("R5 R6 reset mode", 256, 1'b1);
        rd(2'd0, v); chk("R8 flag and mode", v, 32'h6);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd(2'd0, v); chk("R8 flag survives warm reset", v, 32'h4);
        por_n = 1'b0; rst_n = 1'b0;
        idle(2);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);
        rd(2'd0, v); chk("R8 cold reset clears flag", v, 32'h0);

        finish_run();
    end

endmodule